// File: doc/BRIEF.md
# Bus Bridge Error Capture Unit

This unit sits inside a bridge between a local system bus slave port and a PCI-style master/target engine. It receives error events from the PCI side: a master abort or a target abort seen while the bridge masters a cycle, and inbound write words that arrive with a parity bit. Each abort event is tagged with the ID of the requesting local bus master, the request address and the transfer type. Enable masks decide whether the event counts as an error and whether an error line goes back to that master.

The timing of the per-master error line depends on the transfer type. On reads, the error goes out on every data beat of that master until the last beat. On posted writes, it is one pulse that is independent of the beats. On connected writes, it goes out with every beat and the write data is flagged for discard. The unit keeps write-1-to-clear status flags. For each master it also holds one error address register and one syndrome field, each guarded by its own lock bit, so the first failure is preserved until software releases it.

A small synchronous register port reads and writes the control, status, lock, syndrome and address registers. Register map by `reg_addr_i`:
- 0 is control.
- 1 is status.
- 2 is locks.
- 3 is syndrome.
- 4+m is the error address of master m.

Top module: `bridge_err_capture`

## Requirements
- R1: After reset, all registers read 0, `mst_err_o` is 0 and `wdata_drop_o` is 0.
- R2: Control bit 0 enables master aborts and bit 1 enables target aborts. An abort whose own enable is 0 never drives `mst_err_o` and never changes the address, syndrome or lock registers. This holds whatever the value of control bit 2, the assertion enable.
- R3: Status bit 1 (error event) is set in the cycle after any abort whose own enable is 1, even when control bit 2 is 0. Writing 1 to it clears it.
- R4: Status bit 0 (target abort seen) is set in the cycle after every target abort, with no mask. Writing 1 to it clears it.
- R5: After an abort that fires (own enable and control bit 2 both set) on a read (`ev_kind_i`=0), `mst_err_o[m]` is high in every cycle with a beat for master m, up to and including the beat with `beat_last_i`. `wdata_drop_o` stays low.
- R6: After an abort that fires on a posted write (`ev_kind_i`=1), `mst_err_o[m]` is high for exactly the one cycle after the event, without regard to beats.
- R7: After an abort that fires on a connected write (`ev_kind_i`=2), every beat of master m up to the last one asserts both `mst_err_o[m]` and `wdata_drop_o`.
- R8: A firing abort writes `ev_addr_i` into address register 4+m only when address lock bit m (lock register bit m) is 0. In that case it sets that lock bit.
- R9: A firing abort updates syndrome bits [4m+3:4m] only when field lock bit m (lock register bit 4+m) is 0. The update writes type 101b in bits [4m+2:4m] and a read flag in bit 4m+3 (1 for a read, 0 otherwise), and sets that field lock bit.
- R10: Writing 1 to a lock bit clears it, which releases that register for the next capture.
- R11: A parity check word whose data bits and parity bit together hold an odd number of ones sets status bit 2 (parity error), with no mask. It also sets status bit 3 (system error flagged) when control bit 3 is 1. Both bits are write-1-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mab_i | input | 1 | Master abort received, one-cycle event |
| tab_i | input | 1 | Target abort received, one-cycle event |
| ev_mid_i | input | 2 | Master ID of the aborted request |
| ev_kind_i | input | 2 | Transfer type: 0 read, 1 posted write, 2 connected write |
| ev_addr_i | input | 32 | Address of the aborted request |
| pw_valid_i | input | 1 | Inbound write word valid for the parity check |
| pw_data_i | input | 32 | Inbound write data |
| pw_par_i | input | 1 | Parity bit for the data (even parity) |
| beat_valid_i | input | 1 | Local bus data beat in this cycle |
| beat_mid_i | input | 2 | Master that owns the beat |
| beat_last_i | input | 1 | Last beat of the transfer |
| mst_err_o | output | 4 | Per-master error line |
| wdata_drop_o | output | 1 | Discard the write data of this beat |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational |

## Verification
The assertions assume at most one abort (master or target) per cycle. They also assume that beats for a master arrive only after that master's abort event, never in the same cycle, and that the transfer type code 3 is never used. The bench raises a single abort in isolation and keeps the event and the beats of its transfer in separate cycles. It changes the enables only between events and releases the locks and status only while no event is present.

// File: rtl/brerr_pkg.sv
package brerr_pkg;
  typedef enum logic [1:0] {
    XF_READ   = 2'd0,
    XF_POSTED = 2'd1,
    XF_CONN   = 2'd2
  } xfer_e;

  localparam logic [2:0] ETYPE_ABORT = 3'b101;

  localparam int RI_CTRL = 0;
  localparam int RI_STAT = 1;
  localparam int RI_LOCK = 2;
  localparam int RI_SYND = 3;
  localparam int RI_ADDR = 4;

  // even parity: total number of ones over data and parity must be even
  function automatic logic parity_bad(input logic [63:0] data, input int width, input logic par);
    logic acc;
    acc = par;
    for (int i = 0; i < 64; i++)
      if (i < width) acc = acc ^ data[i];
    return acc;
  endfunction

  function automatic logic [3:0] synd_code(input logic is_rd);
    return {is_rd, ETYPE_ABORT};
  endfunction
endpackage

// File: rtl/brerr_par.sv
module brerr_par #(
  parameter int DW = 32
) (
  input  logic          valid_i,
  input  logic [DW-1:0] data_i,
  input  logic          par_i,
  output logic          bad_o
);
  import brerr_pkg::*;
  logic [63:0] wide;
  always_comb begin
    wide = '0;
    wide[DW-1:0] = data_i;
    bad_o = valid_i && parity_bad(wide, DW, par_i);
  end
endmodule

// File: rtl/brerr_log.sv
module brerr_log #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic          alock_clr_i,
  input  logic          flock_clr_i,
  output logic          alock_o,
  output logic          flock_o,
  output logic [AW-1:0] addr_o,
  output logic [3:0]    synd_o
);
  import brerr_pkg::*;
  logic take_addr, take_synd;
  assign take_addr = cap_i && !alock_o;
  assign take_synd = cap_i && !flock_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alock_o <= 1'b0;
      flock_o <= 1'b0;
      addr_o  <= '0;
      synd_o  <= '0;
    end else begin
      if (take_addr) begin
        addr_o  <= addr_i;
        alock_o <= 1'b1;
      end else if (alock_clr_i) begin
        alock_o <= 1'b0;
      end
      if (take_synd) begin
        synd_o  <= synd_code(rd_i);
        flock_o <= 1'b1;
      end else if (flock_clr_i) begin
        flock_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/brerr_sig.sv
module brerr_sig #(
  parameter int NM   = 4,
  parameter int MIDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire_i,
  input  logic [MIDW-1:0] mid_i,
  input  logic [1:0]      kind_i,
  input  logic            beat_valid_i,
  input  logic [MIDW-1:0] beat_mid_i,
  input  logic            beat_last_i,
  output logic [NM-1:0]   err_o,
  output logic            drop_o
);
  import brerr_pkg::*;
  logic [NM-1:0] pend_q, pconn_q, pulse_q, hit;

  for (genvar m = 0; m < NM; m++) begin : g_m
    logic sel;
    assign sel    = fire_i && (mid_i == MIDW'(m));
    assign hit[m] = beat_valid_i && (beat_mid_i == MIDW'(m));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[m]  <= 1'b0;
        pconn_q[m] <= 1'b0;
        pulse_q[m] <= 1'b0;
      end else begin
        pulse_q[m] <= sel && (kind_i == XF_POSTED);
        if (sel && kind_i != XF_POSTED) begin
          pend_q[m]  <= 1'b1;
          pconn_q[m] <= (kind_i != XF_READ);
        end else if (hit[m] && beat_last_i) begin
          pend_q[m]  <= 1'b0;
          pconn_q[m] <= 1'b0;
        end
      end
    end
  end

  assign err_o  = pulse_q | (hit & pend_q);
  assign drop_o = |(hit & pconn_q);
endmodule

// File: rtl/bridge_err_capture.sv
module bridge_err_capture #(
  parameter int NM  = 4,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int RDW = 32,
  localparam int MIDW = $clog2(NM),
  localparam int RAW  = $clog2(NM + 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mab_i,
  input  logic            tab_i,
  input  logic [MIDW-1:0] ev_mid_i,
  input  logic [1:0]      ev_kind_i,
  input  logic [AW-1:0]   ev_addr_i,
  input  logic            pw_valid_i,
  input  logic [DW-1:0]   pw_data_i,
  input  logic            pw_par_i,
  input  logic            beat_valid_i,
  input  logic [MIDW-1:0] beat_mid_i,
  input  logic            beat_last_i,
  output logic [NM-1:0]   mst_err_o,
  output logic            wdata_drop_o,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [RDW-1:0]  reg_wdata_i,
  output logic [RDW-1:0]  reg_rdata_o
);
  import brerr_pkg::*;

  logic [3:0]      ctrl_q, status_q, status_set, status_clr;
  logic            spec_en, abort_fire, par_bad, ev_is_rd;
  logic            we_ctrl, we_stat, we_lock;
  logic [NM-1:0]   alock_v, flock_v;
  logic [AW-1:0]   addr_v [NM];
  logic [4*NM-1:0] synd_v;

  assign spec_en    = (mab_i && ctrl_q[0]) || (tab_i && ctrl_q[1]);
  assign abort_fire = spec_en && ctrl_q[2];
  assign ev_is_rd   = (ev_kind_i == XF_READ);

  assign we_ctrl = reg_we_i && (reg_addr_i == RAW'(RI_CTRL));
  assign we_stat = reg_we_i && (reg_addr_i == RAW'(RI_STAT));
  assign we_lock = reg_we_i && (reg_addr_i == RAW'(RI_LOCK));

  brerr_par #(.DW(DW)) par_i (
    .valid_i(pw_valid_i), .data_i(pw_data_i), .par_i(pw_par_i), .bad_o(par_bad)
  );

  assign status_set = {par_bad && ctrl_q[3], par_bad, spec_en, tab_i};
  assign status_clr = we_stat ? reg_wdata_i[3:0] : 4'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      status_q <= '0;
    end else begin
      if (we_ctrl) ctrl_q <= reg_wdata_i[3:0];
      status_q <= (status_q & ~status_clr) | status_set;
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_log
    brerr_log #(.AW(AW)) log_i (
      .clk(clk), .rst_n(rst_n),
      .cap_i(abort_fire && (ev_mid_i == MIDW'(m))),
      .rd_i(ev_is_rd), .addr_i(ev_addr_i),
      .alock_clr_i(we_lock && reg_wdata_i[m]),
      .flock_clr_i(we_lock && reg_wdata_i[NM+m]),
      .alock_o(alock_v[m]), .flock_o(flock_v[m]),
      .addr_o(addr_v[m]), .synd_o(synd_v[4*m +: 4])
    );
  end

  brerr_sig #(.NM(NM), .MIDW(MIDW)) sig_i (
    .clk(clk), .rst_n(rst_n),
    .fire_i(abort_fire), .mid_i(ev_mid_i), .kind_i(ev_kind_i),
    .beat_valid_i(beat_valid_i), .beat_mid_i(beat_mid_i), .beat_last_i(beat_last_i),
    .err_o(mst_err_o), .drop_o(wdata_drop_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (int'(reg_addr_i))
      RI_CTRL: reg_rdata_o[3:0] = ctrl_q;
      RI_STAT: reg_rdata_o[3:0] = status_q;
      RI_LOCK: reg_rdata_o[2*NM-1:0] = {flock_v, alock_v};
      RI_SYND: reg_rdata_o[4*NM-1:0] = synd_v;
      default: begin
        for (int m = 0; m < NM; m++)
          if (int'(reg_addr_i) == RI_ADDR + m) reg_rdata_o[AW-1:0] = addr_v[m];
      end
    endcase
  end
endmodule

// File: rtl/brerr_chk.sv
module brerr_chk #(
  parameter int NM = 4,
  parameter int DW = 32,
  localparam int MIDW = $clog2(NM)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mab_i,
  input logic            tab_i,
  input logic [MIDW-1:0] ev_mid_i,
  input logic [1:0]      ev_kind_i,
  input logic            pw_valid_i,
  input logic [DW-1:0]   pw_data_i,
  input logic            pw_par_i,
  input logic            beat_valid_i,
  input logic            reg_we_i,
  input logic [NM-1:0]   mst_err_o,
  input logic            wdata_drop_o,
  input logic [3:0]      ctrl_q,
  input logic [3:0]      status_q,
  input logic [NM-1:0]   alock_v,
  input logic            abort_fire
);
  // R4: every target abort leaves its status flag set
  a_r4_ta_seen: assert property (@(posedge clk) disable iff (!rst_n)
    tab_i |=> status_q[0]);

  // R2: a disabled target abort leaves the address locks untouched
  a_r2_ta_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (tab_i && !ctrl_q[1] && !mab_i && !reg_we_i) |=> $stable(alock_v));

  // R6: posted write error shows as a pulse on the owning master's line
  a_r6_posted_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_fire && ev_kind_i == 2'd1) |=> mst_err_o[$past(ev_mid_i)]);

  // R7: discard only ever accompanies a data beat
  a_r7_drop_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_drop_o |-> beat_valid_i);

  // R8: a firing abort leaves its master's address locked
  a_r8_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> alock_v[$past(ev_mid_i)]);

  // R11: an odd count of ones flags the parity status
  a_r11_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (pw_valid_i && ($countones({pw_data_i, pw_par_i}) % 2 == 1)) |=> status_q[2]);
endmodule

bind bridge_err_capture brerr_chk #(.NM(NM), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mab_i(mab_i), .tab_i(tab_i),
  .ev_mid_i(ev_mid_i), .ev_kind_i(ev_kind_i),
  .pw_valid_i(pw_valid_i), .pw_data_i(pw_data_i), .pw_par_i(pw_par_i),
  .beat_valid_i(beat_valid_i), .reg_we_i(reg_we_i),
  .mst_err_o(mst_err_o), .wdata_drop_o(wdata_drop_o),
  .ctrl_q(ctrl_q), .status_q(status_q), .alock_v(alock_v),
  .abort_fire(abort_fire)
);

// File: tb/bridge_err_capture_tb_top.sv
`timescale 1ns/1ps
module bridge_err_capture_tb_top;
  logic clk = 0, rst_n = 0;
  logic mab = 0, tab = 0, pw_valid = 0, pw_par = 0;
  logic beat_valid = 0, beat_last = 0, reg_we = 0;
  logic [1:0] ev_mid = 0, ev_kind = 0, beat_mid = 0;
  logic [31:0] ev_addr = 0, pw_data = 0, reg_wdata = 0, reg_rdata;
  logic [2:0] reg_addr = 0;
  logic [3:0] mst_err;
  logic drop;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bridge_err_capture dut_i (
    .clk(clk), .rst_n(rst_n), .mab_i(mab), .tab_i(tab), .ev_mid_i(ev_mid),
    .ev_kind_i(ev_kind), .ev_addr_i(ev_addr), .pw_valid_i(pw_valid),
    .pw_data_i(pw_data), .pw_par_i(pw_par), .beat_valid_i(beat_valid),
    .beat_mid_i(beat_mid), .beat_last_i(beat_last), .mst_err_o(mst_err),
    .wdata_drop_o(drop), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  // {ctrl[2:0], is_ta, mid[1:0], kind[1:0], fires, event}
  localparam logic [9:0] VEC [8] = '{
    {3'd7, 1'b1, 2'd0, 2'd0, 1'b1, 1'b1},
    {3'd7, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1},
    {3'd7, 1'b1, 2'd2, 2'd2, 1'b1, 1'b1},
    {3'd3, 1'b1, 2'd3, 2'd0, 1'b0, 1'b1},
    {3'd5, 1'b1, 2'd0, 2'd1, 1'b0, 1'b0},
    {3'd5, 1'b0, 2'd3, 2'd2, 1'b1, 1'b1},
    {3'd6, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0},
    {3'd2, 1'b1, 2'd2, 2'd1, 1'b0, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    reg_addr = 3'(a);
    #1 v = reg_rdata;
  endtask

  task automatic fire_ev(input bit is_ta, input logic [1:0] mid, input logic [1:0] kind, input logic [31:0] a);
    @(negedge clk);
    tab = is_ta; mab = !is_ta; ev_mid = mid; ev_kind = kind; ev_addr = a;
    @(negedge clk);
    tab = 0; mab = 0;
  endtask

  task automatic par_word(input logic [31:0] d, input logic p);
    @(negedge clk);
    pw_valid = 1; pw_data = d; pw_par = p;
    @(negedge clk);
    pw_valid = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, pa, ps, a;
    logic [3:0] ctl;
    logic is_ta, fires, evt;
    logic [1:0] mid, kind;
    logic [3:0] ex;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk(mst_err == 0 && drop == 0, "R1 outputs", {27'd0, drop, mst_err}, 0);
    for (int r = 0; r < 8; r++) begin
      rd(r, v);
      chk(v == 0, "R1 register", v, 0);
    end

    foreach (VEC[i]) begin
      {ctl[2:0], is_ta, mid, kind, fires, evt} = VEC[i];
      ctl[3] = 0;
      a = 32'hA000_0100 + 32'(i) * 16;
      wr(0, {28'd0, ctl});
      wr(1, 32'hF);
      wr(2, 32'hFF);
      rd(4 + int'(mid), pa);
      rd(1, v);
      chk(v == 0, "R3 status cleared by write-1", v, 0);
      rd(3, ps);
      fire_ev(is_ta, mid, kind, a);
      #1;
      ex = (fires && kind == 1) ? (4'b1 << mid) : 4'b0;
      chk(mst_err == ex, "R6 posted pulse", {28'd0, mst_err}, {28'd0, ex});
      @(negedge clk); #1;
      chk(mst_err == 0, "R6 pulse lasts one cycle", {28'd0, mst_err}, 0);
      if (kind != 1) begin
        ex = fires ? (4'b1 << mid) : 4'b0;
        for (int b = 0; b < 2; b++) begin
          @(negedge clk);
          beat_valid = 1; beat_mid = mid; beat_last = (b == 1);
          #1;
          chk(mst_err == ex, kind == 0 ? "R5 read beat error" : "R7 connected beat error",
              {28'd0, mst_err}, {28'd0, ex});
          chk(drop == (fires && kind == 2), "R7 discard", {31'd0, drop}, {31'd0, fires && kind == 2});
        end
        @(negedge clk);
        beat_valid = 0; beat_last = 0;
        @(negedge clk);
        beat_valid = 1; beat_mid = mid; #1;
        chk(mst_err == 0, "R5 cleared after last beat", {28'd0, mst_err}, 0);
        @(negedge clk);
        beat_valid = 0;
      end
      rd(1, v);
      chk(v[1] == evt, "R3 event flag", v, {30'd0, evt, 1'b0});
      chk(v[0] == is_ta, "R4 target abort seen", v, {31'd0, is_ta});
      rd(2, v);
      chk(v == (fires ? ((32'h1 << mid) | (32'h10 << mid)) : 0), "R2 R8 locks", v,
          fires ? ((32'h1 << mid) | (32'h10 << mid)) : 0);
      rd(4 + int'(mid), v);
      chk(v == (fires ? a : pa), "R8 address capture", v, fires ? a : pa);
      rd(3, v);
      ps[4*mid +: 4] = fires ? {kind == 0, 3'b101} : ps[4*mid +: 4];
      chk(v == ps, "R9 syndrome", v, ps);
    end

    // R8 R9 R10: first error held, then selective release
    wr(0, 32'h7); wr(2, 32'hFF);
    fire_ev(1, 2'd0, 2'd1, 32'h1111_0000);
    fire_ev(1, 2'd0, 2'd0, 32'h2222_0000);
    rd(4, v);
    chk(v == 32'h1111_0000, "R8 locked address kept", v, 32'h1111_0000);
    rd(3, v);
    chk(v[3:0] == 4'h5, "R9 locked syndrome kept", v, 32'h5);
    wr(2, 32'h01);
    rd(2, v);
    chk(v[0] == 0 && v[4] == 1, "R10 address lock released alone", v, 32'h10);
    fire_ev(1, 2'd0, 2'd0, 32'h3333_0000);
    rd(4, v);
    chk(v == 32'h3333_0000, "R10 address recaptured", v, 32'h3333_0000);
    rd(3, v);
    chk(v[3:0] == 4'h5, "R10 field lock still held", v, 32'h5);
    wr(2, 32'h10);
    fire_ev(0, 2'd0, 2'd0, 32'h4444_0000);
    rd(3, v);
    chk(v[3:0] == 4'hD, "R9 read flag after field release", v, 32'hD);

    // R11 parity
    wr(0, 32'h0); wr(1, 32'hF);
    par_word(32'h0000_0003, 1'b0);
    rd(1, v);
    chk(v[3:2] == 2'b00, "R11 even word accepted", v, 0);
    par_word(32'h0000_0007, 1'b0);
    rd(1, v);
    chk(v[3:2] == 2'b01, "R11 odd word, system error masked", v, 32'h4);
    wr(0, 32'h8);
    par_word(32'h8000_0000, 1'b0);
    rd(1, v);
    chk(v[3:2] == 2'b11, "R11 system error flagged", v, 32'hC);
    wr(1, 32'hC);
    rd(1, v);
    chk(v[3:2] == 2'b00, "R11 write-1 clear", v, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule